// File: doc/BRIEF.md
# MSI Coherence Directory Controller

This block keeps coherence for a small group of private caches that run a three-state MSI protocol. It holds a fixed table of block entries. Each entry stores a protocol state, a sharer bit per cache and a one-hot owner field. Three kinds of messages arrive: cache requests (read-shared, read-modify, and the two eviction notices), data that a cache returns after a forwarded read, and completions from memory (read data or write acknowledge). The block answers on three outputs: a control channel to the caches (invalidate, forwarded reads and eviction acknowledge), a data channel to a requestor that carries an invalidation-ack count, and a memory request channel.

Each cycle the block takes at most one message. A memory completion wins over a cache data response, and a cache data response wins over a cache request. An entry that waits for memory or for a cache holds any new read request at the head of the request input. Eviction notices are still taken in that case. Control and data answers appear one clock after the message is taken. Memory requests appear `MEM_LAT` clocks after it.

Top module: `msi_directory`

## Requirements
- R1: After reset every entry is invalid (no sharers, no owner), and `fwd_valid`, `dat_valid` and `mreq_valid` are low.
- R2: At most one of `mem_ready`, `rsp_ready`, `req_ready` is high in a cycle. A pending memory completion always takes the slot. A cache data response takes it only when no memory completion is pending.
- R3: A read-shared request (`req_type`=0) to an invalid or shared entry issues a memory read (`mreq_write`=0), adds the requestor as a sharer and waits. The memory read data (`mem_ack`=0) is then sent on the data channel to that requestor with an ack count of 0, and the entry becomes shared.
- R4: A read-modify request (`req_type`=1) to an invalid or shared entry issues a memory read and makes the requestor the owner. From shared, it also drops the requestor from the sharers and sends an invalidate (`fwd_type`=0) to the remaining sharers when there are any. The returning data carries an ack count equal to that sharer count, and the entry becomes modified with no sharers.
- R5: A read-shared request to a modified entry forwards it (`fwd_type`=1) to the owner. Both the requestor and the old owner become sharers. Data returned by that cache is written to memory (`mreq_write`=1), and the write acknowledge (`mem_ack`=1) makes the entry shared.
- R6: A read-modify request to a modified entry forwards it (`fwd_type`=2) to the current owner. The requestor becomes the owner and the entry stays modified.
- R7: A dirty eviction (`req_type`=3) from the owner of a modified entry writes `req_data` to memory, clears the owner and is acknowledged (`fwd_type`=3). The entry becomes invalid after the memory write acknowledge.
- R8: A shared eviction (`req_type`=2), or a dirty eviction from a non-owner, to an entry that is invalid, modified or waiting on a read-modify fill or a writeback gets only an acknowledge. It changes no sharer, owner or state.
- R9: A shared eviction to a shared entry counts as last when the sharer count is 1 and that sharer is the requestor. A last eviction makes the entry invalid. Otherwise the requestor is removed, the entry stays shared, and an acknowledge is sent in both cases.
- R10: A read request to an entry in a waiting state is not accepted (`req_ready` low) and changes no state. It is accepted once the entry settles.
- R11: A memory request appears on `mreq_*` exactly `MEM_LAT` clocks after the message that causes it is taken.
- R12: A modified entry always has exactly one owner and no sharers. An invalid entry has neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cache request present |
| req_ready | output | 1 | Cache request taken this cycle |
| req_type | input | 2 | 0 read-shared, 1 read-modify, 2 shared eviction, 3 dirty eviction |
| req_id | input | ID_W | Requesting cache |
| req_idx | input | IDX_W | Entry index |
| req_data | input | DATA_W | Dirty data of an eviction |
| rsp_valid | input | 1 | Cache data response present |
| rsp_ready | output | 1 | Cache data response taken |
| rsp_id | input | ID_W | Sending cache |
| rsp_idx | input | IDX_W | Entry index |
| rsp_data | input | DATA_W | Block data |
| mem_valid | input | 1 | Memory completion present |
| mem_ready | output | 1 | Memory completion taken |
| mem_ack | input | 1 | 1 write acknowledge, 0 read data |
| mem_id | input | ID_W | Cache that caused the access |
| mem_idx | input | IDX_W | Entry index |
| mem_data | input | DATA_W | Read data |
| fwd_valid | output | 1 | Control message valid |
| fwd_type | output | 2 | 0 invalidate, 1 fwd read-shared, 2 fwd read-modify, 3 eviction ack |
| fwd_dest | output | N_CACHE | Destination caches, one bit each |
| fwd_requestor | output | ID_W | Cache whose request caused it |
| fwd_idx | output | IDX_W | Entry index |
| dat_valid | output | 1 | Data answer valid |
| dat_dest | output | ID_W | Receiving cache |
| dat_acks | output | CNT_W | Invalidation acks to expect |
| dat_idx | output | IDX_W | Entry index |
| dat_data | output | DATA_W | Block data |
| mreq_valid | output | 1 | Memory request valid |
| mreq_write | output | 1 | 1 write, 0 read |
| mreq_idx | output | IDX_W | Entry index |
| mreq_id | output | ID_W | Cache on whose behalf |
| mreq_data | output | DATA_W | Write data |

## Verification
The bench targets the ack count on the fill that follows a read-modify from shared. A design that counted before removing the requestor, or after clearing the sharers, would report the wrong number of invalidations. It also holds a read-modify behind a forwarded read while the owner's data and the memory acknowledge arrive. A design that let the held request through, or let it block the response channel, would lose the writeback or deadlock. It then checks evictions that must be last, non-last or stale. A wrong count or owner check would leave an entry shared with no holders, or drop a sharer that still needs an invalidate. Finally, it puts all three inputs up at once to expose a wrong priority order.

// File: rtl/msi_dir_pkg.sv
package msi_dir_pkg;
    typedef enum logic [2:0] {
        ST_I, ST_S, ST_M, ST_SD, ST_SM, ST_MM, ST_MIM, ST_SSM
    } dir_state_e;

    typedef enum logic [1:0] {RQ_GETS, RQ_GETM, RQ_PUTS, RQ_PUTM} req_kind_e;

    typedef enum logic [1:0] {FW_INV, FW_GETS, FW_GETM, FW_PUTACK} fwd_kind_e;
endpackage

// File: rtl/msi_dir_arb.sv
module msi_dir_arb (
    input  logic mem_v,
    input  logic rsp_v,
    input  logic req_v,
    input  logic req_hold,
    output logic mem_go,
    output logic rsp_go,
    output logic req_go
);
    assign mem_go = mem_v;
    assign rsp_go = rsp_v & ~mem_v;
    assign req_go = req_v & ~mem_v & ~rsp_v & ~req_hold;
endmodule

// File: rtl/msi_dir_count.sv
module msi_dir_count #(
    parameter int N     = 4,
    parameter int CNT_W = 3
) (
    input  logic [N-1:0]     bits_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N; i++) cnt_o = cnt_o + CNT_W'(bits_i[i]);
    end
endmodule

// File: rtl/msi_dir_delay.sv
module msi_dir_delay #(
    parameter int W   = 8,
    parameter int LAT = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [LAT];

    genvar g;
    generate
        for (g = 0; g < LAT; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else if (g == 0) stage_q[g] <= din;
                else stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign dout = stage_q[LAT-1];
endmodule

// File: rtl/msi_directory.sv
module msi_directory
    import msi_dir_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_ENTRY = 4,
    parameter int DATA_W  = 32,
    parameter int MEM_LAT = 1,
    localparam int ID_W   = (N_CACHE > 1) ? $clog2(N_CACHE) : 1,
    localparam int IDX_W  = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
    localparam int CNT_W  = $clog2(N_CACHE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_type,
    input  logic [ID_W-1:0]   req_id,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [DATA_W-1:0] req_data,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [ID_W-1:0]   rsp_id,
    input  logic [IDX_W-1:0]  rsp_idx,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              mem_valid,
    output logic              mem_ready,
    input  logic              mem_ack,
    input  logic [ID_W-1:0]   mem_id,
    input  logic [IDX_W-1:0]  mem_idx,
    input  logic [DATA_W-1:0] mem_data,
    output logic              fwd_valid,
    output logic [1:0]        fwd_type,
    output logic [N_CACHE-1:0] fwd_dest,
    output logic [ID_W-1:0]   fwd_requestor,
    output logic [IDX_W-1:0]  fwd_idx,
    output logic              dat_valid,
    output logic [ID_W-1:0]   dat_dest,
    output logic [CNT_W-1:0]  dat_acks,
    output logic [IDX_W-1:0]  dat_idx,
    output logic [DATA_W-1:0] dat_data,
    output logic              mreq_valid,
    output logic              mreq_write,
    output logic [IDX_W-1:0]  mreq_idx,
    output logic [ID_W-1:0]   mreq_id,
    output logic [DATA_W-1:0] mreq_data
);
    localparam int MQ_W = 2 + IDX_W + ID_W + DATA_W;

    typedef struct packed {
        logic               fv;
        logic [1:0]         ft;
        logic [N_CACHE-1:0] fd;
        logic [ID_W-1:0]    fr;
        logic [IDX_W-1:0]   fi;
        logic               dv;
        logic [ID_W-1:0]    dd;
        logic [CNT_W-1:0]   da;
        logic [IDX_W-1:0]   di;
        logic [DATA_W-1:0]  dx;
    } reply_t;

    dir_state_e         st_q  [N_ENTRY];
    dir_state_e         st_d  [N_ENTRY];
    logic [N_CACHE-1:0] shr_q [N_ENTRY];
    logic [N_CACHE-1:0] shr_d [N_ENTRY];
    logic [N_CACHE-1:0] own_q [N_ENTRY];
    logic [N_CACHE-1:0] own_d [N_ENTRY];
    logic [CNT_W-1:0]   cnt   [N_ENTRY];
    reply_t             out_q, out_d;

    logic               m_v, m_w;
    logic [IDX_W-1:0]   m_idx;
    logic [ID_W-1:0]    m_id;
    logic [DATA_W-1:0]  m_data;
    logic [MQ_W-1:0]    mq_out;

    logic               mem_go, rsp_go, req_go, req_hold;
    dir_state_e         req_st;
    logic [N_CACHE-1:0] rbit, rest;
    logic               is_get, put_last, req_own;

    genvar e;
    generate
        for (e = 0; e < N_ENTRY; e++) begin : g_cnt
            msi_dir_count #(.N(N_CACHE), .CNT_W(CNT_W)) i_cnt (
                .bits_i(shr_q[e]), .cnt_o(cnt[e]));
        end
    endgenerate

    assign req_st   = st_q[req_idx];
    assign rbit     = N_CACHE'(1) << req_id;
    assign rest     = shr_q[req_idx] & ~rbit;
    assign is_get   = (req_type == RQ_GETS) || (req_type == RQ_GETM);
    assign req_hold = is_get && !(req_st == ST_I || req_st == ST_S || req_st == ST_M);
    assign put_last = (cnt[req_idx] == CNT_W'(1)) && |(shr_q[req_idx] & rbit);
    assign req_own  = |(own_q[req_idx] & rbit);

    msi_dir_arb i_arb (
        .mem_v(mem_valid), .rsp_v(rsp_valid), .req_v(req_valid), .req_hold(req_hold),
        .mem_go(mem_go), .rsp_go(rsp_go), .req_go(req_go));

    assign mem_ready = mem_go;
    assign rsp_ready = rsp_go;
    assign req_ready = req_go;

    always_comb begin
        for (int i = 0; i < N_ENTRY; i++) begin
            st_d[i]  = st_q[i];
            shr_d[i] = shr_q[i];
            own_d[i] = own_q[i];
        end
        out_d  = '0;
        m_v    = 1'b0;
        m_w    = 1'b0;
        m_idx  = '0;
        m_id   = '0;
        m_data = '0;
        if (mem_go) begin
            out_d.dd = mem_id;
            out_d.di = mem_idx;
            out_d.dx = mem_data;
            out_d.da = own_q[mem_idx][mem_id] ? cnt[mem_idx] : '0;
            case (st_q[mem_idx])
                ST_SM:  if (!mem_ack) begin out_d.dv = 1'b1; st_d[mem_idx] = ST_S; end
                ST_MM:  if (!mem_ack) begin
                            out_d.dv = 1'b1;
                            shr_d[mem_idx] = '0;
                            st_d[mem_idx]  = ST_M;
                        end
                ST_MIM: if (mem_ack) st_d[mem_idx] = ST_I;
                ST_SSM: if (mem_ack) st_d[mem_idx] = ST_S;
                default: ;
            endcase
        end else if (rsp_go) begin
            if (st_q[rsp_idx] == ST_SD) begin
                m_v = 1'b1; m_w = 1'b1;
                m_idx = rsp_idx; m_id = rsp_id; m_data = rsp_data;
                st_d[rsp_idx] = ST_SSM;
            end
        end else if (req_go) begin
            out_d.fi = req_idx;
            out_d.fr = req_id;
            out_d.fd = rbit;
            m_idx = req_idx; m_id = req_id; m_data = req_data;
            case (req_type)
                RQ_GETS: if (req_st == ST_M) begin
                        out_d.fv = 1'b1; out_d.ft = FW_GETS; out_d.fd = own_q[req_idx];
                        shr_d[req_idx] = shr_q[req_idx] | rbit | own_q[req_idx];
                        own_d[req_idx] = '0;
                        st_d[req_idx]  = ST_SD;
                    end else begin
                        m_v = 1'b1;
                        shr_d[req_idx] = shr_q[req_idx] | rbit;
                        st_d[req_idx]  = ST_SM;
                    end
                RQ_GETM: if (req_st == ST_M) begin
                        out_d.fv = 1'b1; out_d.ft = FW_GETM; out_d.fd = own_q[req_idx];
                        own_d[req_idx] = rbit;
                    end else begin
                        m_v = 1'b1;
                        own_d[req_idx] = rbit;
                        st_d[req_idx]  = ST_MM;
                        if (req_st == ST_S) begin
                            shr_d[req_idx] = rest;
                            out_d.fv = |rest; out_d.ft = FW_INV; out_d.fd = rest;
                        end
                    end
                default: begin
                    out_d.fv = 1'b1;
                    out_d.ft = FW_PUTACK;
                    case (req_st)
                        ST_M: if (req_type == RQ_PUTM && req_own) begin
                                m_v = 1'b1; m_w = 1'b1;
                                own_d[req_idx] = '0;
                                st_d[req_idx]  = ST_MIM;
                            end
                        ST_S: begin
                                shr_d[req_idx] = rest;
                                if (req_type == RQ_PUTS && put_last) st_d[req_idx] = ST_I;
                            end
                        ST_SD, ST_SM, ST_SSM: shr_d[req_idx] = rest;
                        default: ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRY; i++) begin
                st_q[i]  <= ST_I;
                shr_q[i] <= '0;
                own_q[i] <= '0;
            end
            out_q <= '0;
        end else begin
            for (int i = 0; i < N_ENTRY; i++) begin
                st_q[i]  <= st_d[i];
                shr_q[i] <= shr_d[i];
                own_q[i] <= own_d[i];
            end
            out_q <= out_d;
        end
    end

    msi_dir_delay #(.W(MQ_W), .LAT(MEM_LAT)) i_mdly (
        .clk(clk), .rst_n(rst_n),
        .din({m_v, m_w, m_idx, m_id, m_data}),
        .dout(mq_out));

    assign {mreq_valid, mreq_write, mreq_idx, mreq_id, mreq_data} = mq_out;
    assign fwd_valid     = out_q.fv;
    assign fwd_type      = out_q.ft;
    assign fwd_dest      = out_q.fd;
    assign fwd_requestor = out_q.fr;
    assign fwd_idx       = out_q.fi;
    assign dat_valid     = out_q.dv;
    assign dat_dest      = out_q.dd;
    assign dat_acks      = out_q.da;
    assign dat_idx       = out_q.di;
    assign dat_data      = out_q.dx;

    // Arbitration: one slot, memory first, then cache data responses.
    p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_ready, rsp_ready, req_ready}));
    p_mem_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (!rsp_ready && !req_ready));
    // A data answer only follows a taken memory read completion.
    p_dat_from_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> $past(mem_ready && !mem_ack));
    // Control messages only follow a taken cache request.
    p_fwd_from_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(req_ready));

    generate
        for (e = 0; e < N_ENTRY; e++) begin : g_chk
            p_m_one_owner_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q[e] == ST_M) |-> ($countones(own_q[e]) == 1 && shr_q[e] == '0));
            p_i_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q[e] == ST_I) |-> (own_q[e] == '0 && shr_q[e] == '0));
            p_hold_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && !req_ready && !mem_valid && !rsp_valid) |=> $stable(st_q[e]));
        end
    endgenerate
endmodule

// File: tb/test_msi_directory.sv
module test_msi_directory;
    localparam int NC = 4, NE = 4, DW = 32, MLAT = 2;
    localparam int IDW = 2, IXW = 2, CW = 3;
    localparam int XI = 0, XS = 1, XM = 2, XSD = 3, XSM = 4, XMM = 5, XMIM = 6, XSSM = 7;

    typedef struct {int kind; int id; int idx; int data;} msg_t;
    typedef struct {int v; int w; int idx; int id; int data;} mrq_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, rsp_valid = 0, mem_valid = 0, mem_ack = 0;
    logic [1:0] req_type = 0;
    logic [IDW-1:0] req_id = 0, rsp_id = 0, mem_id = 0;
    logic [IXW-1:0] req_idx = 0, rsp_idx = 0, mem_idx = 0;
    logic [DW-1:0] req_data = 0, rsp_data = 0, mem_data = 0;
    logic req_ready, rsp_ready, mem_ready;
    logic fwd_valid, dat_valid, mreq_valid, mreq_write;
    logic [1:0] fwd_type;
    logic [NC-1:0] fwd_dest;
    logic [IDW-1:0] fwd_requestor, dat_dest, mreq_id;
    logic [IXW-1:0] fwd_idx, dat_idx, mreq_idx;
    logic [CW-1:0] dat_acks;
    logic [DW-1:0] dat_data, mreq_data;

    always #2 clk = ~clk;

    msi_directory #(.N_CACHE(NC), .N_ENTRY(NE), .DATA_W(DW), .MEM_LAT(MLAT)) i_msi_directory (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type), .req_id(req_id),
        .req_idx(req_idx), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_idx(rsp_idx),
        .rsp_data(rsp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_ack(mem_ack), .mem_id(mem_id),
        .mem_idx(mem_idx), .mem_data(mem_data),
        .fwd_valid(fwd_valid), .fwd_type(fwd_type), .fwd_dest(fwd_dest),
        .fwd_requestor(fwd_requestor), .fwd_idx(fwd_idx),
        .dat_valid(dat_valid), .dat_dest(dat_dest), .dat_acks(dat_acks), .dat_idx(dat_idx),
        .dat_data(dat_data),
        .mreq_valid(mreq_valid), .mreq_write(mreq_write), .mreq_idx(mreq_idx),
        .mreq_id(mreq_id), .mreq_data(mreq_data));

    msg_t reqq[$], rspq[$], memq[$];
    int st[NE], shr[NE], own[NE], memarr[NE];
    mrq_t mp[MLAT];
    int e_fv, e_ft, e_fd, e_fr, e_fi, e_dv, e_dd, e_da, e_di, e_dx;
    int vectors = 0, misses = 0;
    bit done = 0;
    string tag = "R1";

    task automatic chk(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_regs();
        chk("fwd_valid", fwd_valid, e_fv);
        if (e_fv != 0) begin
            chk("fwd_type", fwd_type, e_ft);
            chk("fwd_dest", fwd_dest, e_fd);
            chk("fwd_requestor", fwd_requestor, e_fr);
            chk("fwd_idx", fwd_idx, e_fi);
        end
        chk("dat_valid", dat_valid, e_dv);
        if (e_dv != 0) begin
            chk("dat_dest", dat_dest, e_dd);
            chk("dat_acks", dat_acks, e_da);
            chk("dat_idx", dat_idx, e_di);
            chk("dat_data", dat_data, e_dx);
        end
        // R11: memory request seen exactly MLAT clocks after acceptance
        chk("mreq_valid", mreq_valid, mp[MLAT-1].v);
        if (mp[MLAT-1].v != 0) begin
            chk("mreq_write", mreq_write, mp[MLAT-1].w);
            chk("mreq_idx", mreq_idx, mp[MLAT-1].idx);
            chk("mreq_id", mreq_id, mp[MLAT-1].id);
            if (mp[MLAT-1].w != 0) chk("mreq_data", mreq_data, mp[MLAT-1].data);
            if (mp[MLAT-1].w != 0) begin
                memarr[mp[MLAT-1].idx] = mp[MLAT-1].data;
                memq.push_back('{1, mp[MLAT-1].id, mp[MLAT-1].idx, 0});
            end else begin
                memq.push_back('{0, mp[MLAT-1].id, mp[MLAT-1].idx, memarr[mp[MLAT-1].idx]});
            end
        end
    endtask

    task automatic drive();
        req_valid = reqq.size() > 0;
        if (reqq.size() > 0) begin
            req_type = reqq[0].kind[1:0]; req_id = reqq[0].id[IDW-1:0];
            req_idx = reqq[0].idx[IXW-1:0]; req_data = reqq[0].data;
        end
        rsp_valid = rspq.size() > 0;
        if (rspq.size() > 0) begin
            rsp_id = rspq[0].id[IDW-1:0]; rsp_idx = rspq[0].idx[IXW-1:0];
            rsp_data = rspq[0].data;
        end
        mem_valid = memq.size() > 0;
        if (memq.size() > 0) begin
            mem_ack = memq[0].kind[0]; mem_id = memq[0].id[IDW-1:0];
            mem_idx = memq[0].idx[IXW-1:0]; mem_data = memq[0].data;
        end
    endtask

    task automatic step();
        int mv, rv, qv, hold, gm, gr, gq, b, rest, x;
        msg_t m;
        mrq_t nm;
        nm = '{0, 0, 0, 0, 0};
        mv = memq.size() > 0; rv = rspq.size() > 0; qv = reqq.size() > 0;
        hold = 0;
        if (qv != 0 && reqq[0].kind < 2 && !(st[reqq[0].idx] inside {XI, XS, XM})) hold = 1;
        gm = mv; gr = rv && !mv; gq = qv && !mv && !rv && !hold;
        chk("mem_ready R2", mem_ready, gm);
        chk("rsp_ready R2", rsp_ready, gr);
        chk("req_ready R10", req_ready, gq);
        e_fv = 0; e_dv = 0;
        if (gm != 0) begin
            m = memq.pop_front();
            x = m.idx;
            e_dd = m.id; e_di = x; e_dx = m.data;
            e_da = ((own[x] >> m.id) & 1) != 0 ? $countones(shr[x]) : 0;
            if (m.kind == 0 && st[x] == XSM) begin e_dv = 1; st[x] = XS; end
            else if (m.kind == 0 && st[x] == XMM) begin e_dv = 1; shr[x] = 0; st[x] = XM; end
            else if (m.kind == 1 && st[x] == XMIM) st[x] = XI;
            else if (m.kind == 1 && st[x] == XSSM) st[x] = XS;
        end else if (gr != 0) begin
            m = rspq.pop_front();
            if (st[m.idx] == XSD) begin
                nm = '{1, 1, m.idx, m.id, m.data};
                st[m.idx] = XSSM;
            end
        end else if (gq != 0) begin
            m = reqq.pop_front();
            x = m.idx; b = 1 << m.id; rest = shr[x] & ~b;
            e_fi = x; e_fr = m.id;
            if (m.kind == 0) begin
                if (st[x] == XM) begin
                    e_fv = 1; e_ft = 1; e_fd = own[x];
                    shr[x] = shr[x] | b | own[x]; own[x] = 0; st[x] = XSD;
                end else begin
                    nm = '{1, 0, x, m.id, 0}; shr[x] |= b; st[x] = XSM;
                end
            end else if (m.kind == 1) begin
                if (st[x] == XM) begin
                    e_fv = 1; e_ft = 2; e_fd = own[x]; own[x] = b;
                end else begin
                    nm = '{1, 0, x, m.id, 0};
                    if (st[x] == XS) begin
                        shr[x] = rest;
                        if (rest != 0) begin e_fv = 1; e_ft = 0; e_fd = rest; end
                    end
                    own[x] = b; st[x] = XMM;
                end
            end else begin
                e_fv = 1; e_ft = 3; e_fd = b;
                if (st[x] == XM && m.kind == 3 && own[x] == b) begin
                    nm = '{1, 1, x, m.id, m.data}; own[x] = 0; st[x] = XMIM;
                end else if (st[x] == XS) begin
                    if (m.kind == 2 && $countones(shr[x]) == 1 && (shr[x] & b) != 0) st[x] = XI;
                    shr[x] = rest;
                end else if (st[x] inside {XSD, XSM, XSSM}) begin
                    shr[x] = rest;
                end
            end
        end
        for (int i = MLAT - 1; i > 0; i--) mp[i] = mp[i-1];
        mp[0] = nm;
    endtask

    task automatic tick();
        @(negedge clk);
        check_regs();
        drive();
        #1;
        step();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rq(int kind, int id, int idx, int data);
        reqq.push_back('{kind, id, idx, data});
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            st[i] = XI; shr[i] = 0; own[i] = 0; memarr[i] = 'hA000 + i;
        end
        for (int i = 0; i < MLAT; i++) mp[i] = '{0, 0, 0, 0, 0};
        e_fv = 0; e_ft = 0; e_fd = 0; e_fr = 0; e_fi = 0;
        e_dv = 0; e_dd = 0; e_da = 0; e_di = 0; e_dx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        tag = "R1"; run(2);                         // reset state, outputs idle
        tag = "R3"; rq(0, 0, 0, 0); run(10); rq(0, 1, 0, 0); run(10);
        tag = "R4"; rq(1, 2, 0, 0); run(10);        // inv {c0,c1}, acks 2
        tag = "R6"; rq(1, 3, 0, 0); run(6);
        tag = "R5"; rq(0, 1, 0, 0); run(6);
        tag = "R10"; rq(1, 0, 0, 0); run(6);        // held behind S_D
        tag = "R5"; rspq.push_back('{0, 3, 0, 'h55}); run(16);
        tag = "R7"; rq(3, 0, 0, 'h77); run(10);
        tag = "R8"; rq(2, 1, 0, 0); rq(3, 2, 0, 9); run(6);
        tag = "R12"; rq(1, 1, 0, 0); run(10);       // from empty I: no inv, acks 0
        tag = "R9"; rq(0, 0, 1, 0); run(10); rq(0, 1, 1, 0); run(10);
        rq(2, 0, 1, 0); run(4); rq(2, 2, 1, 0); run(4); rq(2, 1, 1, 0); run(4);
        rq(1, 3, 1, 0); run(10);
        tag = "R2"; memq.push_back('{1, 0, 3, 0}); rspq.push_back('{0, 1, 3, 4});
        rq(0, 0, 2, 0); run(10);
        tag = "R8"; rq(1, 1, 3, 0); rq(2, 2, 3, 0); run(10);
        rq(3, 2, 3, 5); run(4); rq(0, 0, 3, 0); run(6);
        tag = "R11"; rq(1, 2, 2, 0); run(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule